// File: doc/BRIEF.md
# Remappable System Address Decoder

This block sits between a 32-bit processor address bus and the on-chip memories. It turns each address into exactly one select, for the SRAM, the Flash array or the memory-mapped register space. It also produces the byte offset local to the chosen target. An address in the unmapped gaps raises an error flag instead. Before any other region is tried, the lowest part of the address space is an alias window. A remap control bit picks whether this window shows Flash or SRAM, so the same low addresses can reach either memory.

The decoder also reports when an access is complete. SRAM, Flash and registers on the fast system bus finish in the cycle the access is presented. Registers on the slower peripheral bus need a second cycle. For register addresses, the sub-decode of the register space supplies a hint saying which bus the target is on. The last 2 KB of Flash hold the boot code, and writes there made in user mode are refused. The master holds the address and controls stable while `valid` is high and `ready` is low.

Top module: `sys_addr_decode`

## Requirements
- R1: While `valid` is low, and during reset, `sel_sram`, `sel_flash`, `sel_mmr`, `err` and `ready` are all low.
- R2: An address in 0x00040000..0x00041FFF asserts `sel_sram` with `offset` = address − 0x00040000.
- R3: An address in 0x00080000..0x0009FFFF asserts `sel_flash` with `offset` = address − 0x00080000 (unless R9 blocks it).
- R4: An address in 0xFFFF0000..0xFFFFFFFF asserts `sel_mmr` with `offset` = address − 0xFFFF0000, zero-extended.
- R5: With `alias_flash` = 1, an address in 0x00000000..0x0001FFFF selects Flash with `offset` = address bits [16:0].
- R6: With `alias_flash` = 0, an address in 0x00000000..0x0001FFFF selects SRAM with `offset` = address modulo 8192, so the 8 KB image repeats across the window.
- R7: The alias target follows the level of `alias_flash` in the first cycle of each access, so a change applies from the next access onward.
- R8: Any other address asserts `err`, drives no select, and completes with `ready` in its first cycle.
- R9: A write (`write` = 1) in user mode (`user_mode` = 1) to the boot page asserts `err` and no select. The boot page is Flash offsets 0x1F800..0x1FFFF, reached directly at 0x0009F800 or through the Flash alias at 0x0001F800. Reads and privileged writes to it are selected as normal.
- R10: SRAM, Flash, error and register accesses with `periph_fast` = 1 raise `ready` in the first cycle of the access.
- R11: A register access with `periph_fast` = 0 keeps `ready` low in its first cycle and raises it in the second, with select and offset held.
- R12: At most one select is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Access request, held until `ready` |
| write | input | 1 | 1 = write access |
| user_mode | input | 1 | 1 = unprivileged access |
| alias_flash | input | 1 | 1 = low window shows Flash, 0 = SRAM |
| periph_fast | input | 1 | Register target is on the fast bus |
| addr | input | 32 | Byte address |
| sel_sram | output | 1 | SRAM select |
| sel_flash | output | 1 | Flash select |
| sel_mmr | output | 1 | Register space select |
| offset | output | 17 | Target-local byte offset |
| err | output | 1 | Unmapped or refused access |
| ready | output | 1 | Access completes this cycle |

## Verification
The bench builds the decoder with its default parameters: an 8 KB SRAM, a 128 KB Flash with a 2 KB boot page, and a 128 KB alias window. With these values the SRAM image repeats sixteen times inside the alias window, so the modulo offset can be seen directly. The boot page can also be reached through both the direct and the aliased address. Every region edge is in 32-bit reach, so the edges and the holes beside them are exercised with directed addresses. Random traffic, weighted per region, then mixes both alias settings, both bus speeds and all write and privilege combinations.

// File: rtl/sys_addr_decode.sv
module sys_addr_decode #(
  parameter int AW = 32,
  parameter logic [31:0] SRAM_BASE  = 32'h0004_0000,
  parameter int SRAM_AW  = 13,
  parameter logic [31:0] FLASH_BASE = 32'h0008_0000,
  parameter int FLASH_AW = 17,
  parameter int BOOT_AW  = 11,
  parameter int ALIAS_AW = 17,
  parameter int MMR_AW   = 16,
  localparam int OFS_W = (FLASH_AW > MMR_AW) ? ((FLASH_AW > SRAM_AW) ? FLASH_AW : SRAM_AW)
                                             : ((MMR_AW > SRAM_AW) ? MMR_AW : SRAM_AW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             write,
  input  logic             user_mode,
  input  logic             alias_flash,
  input  logic             periph_fast,
  input  logic [AW-1:0]    addr,
  output logic             sel_sram,
  output logic             sel_flash,
  output logic             sel_mmr,
  output logic [OFS_W-1:0] offset,
  output logic             err,
  output logic             ready
);

  logic in_alias, in_sram, in_flash, in_mmr;
  logic flash_hit, sram_hit, boot_hit, blocked, slow, busy;

  assign in_alias = (addr[AW-1:ALIAS_AW] == '0);
  assign in_sram  = (addr[AW-1:SRAM_AW]  == SRAM_BASE[AW-1:SRAM_AW]);
  assign in_flash = (addr[AW-1:FLASH_AW] == FLASH_BASE[AW-1:FLASH_AW]);
  assign in_mmr   = &addr[AW-1:MMR_AW];

  assign flash_hit = in_flash | (in_alias & alias_flash);
  assign sram_hit  = in_sram  | (in_alias & ~alias_flash);
  assign boot_hit  = flash_hit & (&addr[FLASH_AW-1:BOOT_AW]);
  assign blocked   = boot_hit & write & user_mode;

  assign sel_sram  = valid & sram_hit;
  assign sel_flash = valid & flash_hit & ~blocked;
  assign sel_mmr   = valid & in_mmr;
  assign err       = valid & ~(sel_sram | sel_flash | sel_mmr);

  always_comb begin
    offset = '0;
    if (sel_sram)  offset[SRAM_AW-1:0]  = addr[SRAM_AW-1:0];
    if (sel_flash) offset[FLASH_AW-1:0] = addr[FLASH_AW-1:0];
    if (sel_mmr)   offset[MMR_AW-1:0]   = addr[MMR_AW-1:0];
  end

  assign slow  = sel_mmr & ~periph_fast;
  assign ready = valid & (~slow | busy);

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= slow & ~busy;
  end

endmodule

// File: rtl/sys_addr_decode_chk.sv
module sys_addr_decode_chk #(
  parameter int AW = 32,
  parameter logic [31:0] FLASH_BASE = 32'h0008_0000,
  parameter int FLASH_AW = 17,
  parameter int BOOT_AW  = 11,
  parameter int OFS_W    = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid,
  input logic             write,
  input logic             user_mode,
  input logic             periph_fast,
  input logic [AW-1:0]    addr,
  input logic             sel_sram,
  input logic             sel_flash,
  input logic             sel_mmr,
  input logic [OFS_W-1:0] offset,
  input logic             err,
  input logic             ready
);

  logic in_boot;
  assign in_boot = (addr[AW-1:BOOT_AW] == {FLASH_BASE[AW-1:FLASH_AW], {(FLASH_AW-BOOT_AW){1'b1}}});

  a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_sram, sel_flash, sel_mmr}));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !(sel_sram || sel_flash || sel_mmr || err || ready));

  a_r8_err_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(sel_sram || sel_flash || sel_mmr) && ready);

  a_r9_boot_block: assert property (@(posedge clk) disable iff (!rst_n)
    valid && write && user_mode && in_boot |-> err && !sel_flash);

  a_r10_fast_ready: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (sel_sram || sel_flash || (sel_mmr && periph_fast)) |-> ready);

  a_r11_slow_wait: assert property (@(posedge clk) disable iff (!rst_n)
    valid && sel_mmr && !periph_fast && !ready |=> ready || !valid);

  a_r11_slow_second: assert property (@(posedge clk) disable iff (!rst_n)
    valid && sel_mmr && !periph_fast && ready |-> $past(valid) && !$past(ready) && $stable(offset));

endmodule

bind sys_addr_decode sys_addr_decode_chk #(
  .AW(AW), .FLASH_BASE(FLASH_BASE), .FLASH_AW(FLASH_AW), .BOOT_AW(BOOT_AW), .OFS_W(OFS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .write(write), .user_mode(user_mode),
  .periph_fast(periph_fast), .addr(addr), .sel_sram(sel_sram), .sel_flash(sel_flash),
  .sel_mmr(sel_mmr), .offset(offset), .err(err), .ready(ready)
);

// File: tb/test_sys_addr_decode.sv
module test_sys_addr_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, write = 1'b0, user_mode = 1'b0, alias_flash = 1'b1, periph_fast = 1'b0;
  logic [31:0] addr = '0;
  logic sel_sram, sel_flash, sel_mmr, err, ready;
  logic [16:0] offset;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  sys_addr_decode i_sys_addr_decode (
    .clk(clk), .rst_n(rst_n), .valid(valid), .write(write), .user_mode(user_mode),
    .alias_flash(alias_flash), .periph_fast(periph_fast), .addr(addr),
    .sel_sram(sel_sram), .sel_flash(sel_flash), .sel_mmr(sel_mmr),
    .offset(offset), .err(err), .ready(ready)
  );

  // {sram, flash, mmr, err, slow, offset[16:0]}
  function automatic logic [21:0] model(input logic [31:0] a, input logic w, u, af, pf);
    logic s = 0, f = 0, m = 0, e = 0, sl = 0;
    logic [31:0] o = 0;
    if (a < 32'h0002_0000) begin
      if (af) begin
        if (a >= 32'h0001_F800 && w && u) e = 1; else begin f = 1; o = a; end
      end else begin s = 1; o = a % 32'd8192; end
    end else if (a >= 32'h0004_0000 && a <= 32'h0004_1FFF) begin s = 1; o = a - 32'h0004_0000; end
    else if (a >= 32'h0008_0000 && a <= 32'h0009_FFFF) begin
      if (a >= 32'h0009_F800 && w && u) e = 1; else begin f = 1; o = a - 32'h0008_0000; end
    end else if (a >= 32'hFFFF_0000) begin m = 1; sl = !pf; o = a - 32'hFFFF_0000; end
    else e = 1;
    return {s, f, m, e, sl, o[16:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s addr=%h got=%h exp=%h", req, addr, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 0;
    #5;
    check("R1", {sel_sram, sel_flash, sel_mmr, err, ready}, 0);
    @(posedge clk);
  endtask

  task automatic acc(input logic [31:0] a, input logic w, u, af, pf, input string req);
    logic [21:0] x;
    x = model(a, w, u, af, pf);
    @(negedge clk);
    addr = a; write = w; user_mode = u; alias_flash = af; periph_fast = pf; valid = 1;
    #5;
    check(req, {sel_sram, sel_flash, sel_mmr, err}, x[21:18]);
    check(req, offset, x[16:0]);
    check(x[17] ? "R11" : "R10", ready, !x[17]);
    @(posedge clk);
    if (x[17]) begin
      #5;
      check("R11", {ready, sel_mmr, offset}, {2'b11, x[16:0]});
      @(posedge clk);
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #5 check("R1", {sel_sram, sel_flash, sel_mmr, err, ready}, 0);
    @(negedge clk) rst_n = 1;
    idle();
    acc(32'h0004_0000, 0, 1, 1, 0, "R2");
    acc(32'h0004_1FFF, 1, 1, 1, 0, "R2");
    acc(32'h0004_2000, 0, 1, 1, 0, "R8");
    acc(32'h0003_FFFF, 0, 1, 1, 0, "R8");
    acc(32'h0008_0000, 0, 1, 1, 0, "R3");
    acc(32'h0007_FFFF, 0, 1, 1, 0, "R8");
    acc(32'h0009_F7FF, 1, 1, 1, 0, "R3");
    acc(32'h0009_F800, 1, 1, 1, 0, "R9");
    acc(32'h0009_F800, 0, 1, 1, 0, "R9");
    acc(32'h0009_FFFF, 1, 0, 1, 0, "R9");
    acc(32'h000A_0000, 0, 0, 1, 0, "R8");
    acc(32'hFFFE_FFFF, 0, 0, 1, 0, "R8");
    acc(32'hFFFF_0000, 0, 0, 1, 0, "R4");
    acc(32'hFFFF_FFFF, 1, 0, 1, 1, "R4");
    acc(32'h0001_FFFF, 0, 1, 1, 0, "R5");
    acc(32'h0001_F800, 1, 1, 1, 0, "R9");
    acc(32'h0001_F800, 1, 1, 0, 0, "R6");
    acc(32'h0001_2345, 0, 1, 0, 0, "R6");
    acc(32'h0002_0000, 0, 1, 0, 0, "R8");
    acc(32'h0000_0010, 0, 1, 1, 0, "R7");
    acc(32'h0000_0010, 0, 1, 0, 0, "R7");
    acc(32'h0000_2010, 0, 1, 1, 0, "R7");
    acc(32'hFFFF_1234, 0, 1, 0, 0, "R11");
    acc(32'h0000_0004, 0, 1, 0, 1, "R7");
    idle();
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      string req;
      int k;
      k = $urandom_range(0, 5);
      case (k)
        0: begin a = $urandom_range(0, 32'h1FFFF); req = "R5"; end
        1: begin a = 32'h0004_0000 + $urandom_range(0, 32'h1FFF); req = "R2"; end
        2: begin a = 32'h0008_0000 + $urandom_range(0, 32'h1FFFF); req = "R3"; end
        3: begin a = 32'h0009_F800 + $urandom_range(0, 32'h7FF); req = "R9"; end
        4: begin a = 32'hFFFF_0000 + $urandom_range(0, 32'hFFFF); req = "R4"; end
        default: begin a = $urandom; req = "R8"; end
      endcase
      acc(a, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), req);
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule